// File: doc/BRIEF.md
# Selectable Reset Source Controller

This block collects the internal reset requests of a line-interface device and turns the selected ones into a single active-low reset pulse on an output pin. There are three hardware requests, each arriving as a one-cycle strobe: a control/indication code change (the exchange side waking up), a subscriber wake-up event and a watchdog expiry. A fourth request comes from software through a self-clearing software reset register. A two-bit select field in the mode register chooses which hardware requests may reach the pin. Every forwarded request is stretched into a pulse whose length is bounded by an 8 kHz frame tick, so the pin stays low for at least one and at most two frame periods.

The software reset register also carries one bit per functional block. Writing a one to such a bit produces a one-cycle reset strobe for the registers in that block's address range. A small decoder reports whether the register at a given address is being cleared in the current cycle. A forwarded hardware request returns the mode register to its reset value. The external reset input clears every register of the block.

The pulse timer is a three-state machine. PS_IDLE holds the pin high. A trigger moves it to PS_ARMED (transition "fire"), which drives the pin low and waits for the first frame tick. That tick moves it to PS_HOLD (transition "first tick"), which keeps the pin low. The next tick returns it to PS_IDLE (transition "release"). A trigger that arrives in PS_ARMED or PS_HOLD is ignored.

Top module: `rstsel_top`

## Requirements
- R1: After the external reset input `rst_n` is released, `rst_o_n` is 1, `mode_sel` is 00 and `blk_rst` is all zero.
- R2: With `mode_sel` = 00, a `cic_evt` or `saw_evt` strobe drives `rst_o_n` low from the cycle after the strobe, and a `wdog_evt` strobe is ignored.
- R3: With `mode_sel` = 10 or 11, a `wdog_evt` strobe drives `rst_o_n` low from the cycle after the strobe, and `cic_evt` and `saw_evt` are ignored.
- R4: With `mode_sel` = 01, no hardware strobe reaches `rst_o_n`. Only the software pin request (bit 6 of the software reset word) still produces a pulse.
- R5: Every low pulse on `rst_o_n` lasts between TICK_CYCLES+1 and 2*TICK_CYCLES clock cycles. It ends on the second frame tick after it starts.
- R6: A request that arrives while a pulse is active neither extends nor restarts that pulse.
- R7: A forwarded hardware request sets `mode_sel` to 00 in the next cycle and takes priority over a `mode_wr` in the same cycle. A request that is not forwarded leaves `mode_sel` unchanged.
- R8: A `sw_wr` with bit k (k = 0..5) of `sw_wdata` set raises `blk_rst[k]` for exactly the one cycle after the write. The register then clears itself without another write.
- R9: A software pin request creates a pulse under every select value and does not change `mode_sel`.
- R10: `reg_clr` is high exactly when `reg_addr` lies in the range of a block whose strobe is active. The ranges are: block 0 00–2F, block 1 30–3F, block 2 40–5B, block 3 5C–5F, block 4 60–6F, block 5 70–7F (hex).
- R11: `mode_wr` loads `mode_wdata` into the select field, which is visible on `mode_sel` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, clears all registers |
| cic_evt | input | 1 | Control/indication code change strobe |
| saw_evt | input | 1 | Subscriber wake-up strobe |
| wdog_evt | input | 1 | Watchdog expiry strobe |
| mode_wr | input | 1 | Write enable for the select field |
| mode_wdata | input | 2 | New select value |
| sw_wr | input | 1 | Write enable for the software reset word |
| sw_wdata | input | 7 | Bits 5:0 are block reset requests, bit 6 is the pin request |
| reg_addr | input | 7 | Register address to check against the active strobes |
| rst_o_n | output | 1 | Reset output pin, active low |
| mode_sel | output | 2 | Current select field |
| blk_rst | output | 6 | One-cycle reset strobes, one per address range |
| reg_clr | output | 1 | High when the register at `reg_addr` is being reset |

## Verification
The bench builds the block with TICK_CYCLES = 8 in place of the 15625 needed for a 125 µs frame at 125 MHz. This keeps a whole pulse within 9 to 16 cycles, so the bench can run many pulses under every select code. It also makes the upper width bound, and the ignoring of repeated requests during a pulse, observable in a short run. The address ranges are fixed, so every range edge, and the address just outside it, is checked directly at the default width.

// File: rtl/rstsel_pkg.sv
package rstsel_pkg;

    localparam int NBLK    = 6;
    localparam int AW      = 7;
    localparam int SWW     = NBLK + 1;
    localparam int PIN_BIT = NBLK;

    typedef logic [AW-1:0] addr_t;

    // upper address of each functional block range, ascending
    localparam addr_t BLK_HI [NBLK] = '{7'h2F, 7'h3F, 7'h5B, 7'h5F, 7'h6F, 7'h7F};

    localparam logic [1:0] SEL_WAKE = 2'b00;
    localparam logic [1:0] SEL_RSVD = 2'b01;
    localparam logic [1:0] MODE_RST = SEL_WAKE;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ARMED = 2'd1,
        PS_HOLD  = 2'd2
    } pulse_st_e;

endpackage

// File: rtl/rstsel_tick.sv
module rstsel_tick #(
    parameter int TICK_CYCLES = 15625
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == LAST);
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rstsel_src_gate.sv
module rstsel_src_gate
    import rstsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cic_evt,
    input  logic       saw_evt,
    input  logic       wdog_evt,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    output logic [1:0] mode_sel,
    output logic       hw_fwd
);
    logic [1:0] mode_q;
    logic       wake_fwd;
    logic       wdog_fwd;

    always_comb begin
        wake_fwd = (mode_q == SEL_WAKE) && (cic_evt || saw_evt);
        wdog_fwd = mode_q[1] && wdog_evt;
        hw_fwd   = wake_fwd || wdog_fwd;
    end

    // a forwarded source restores the reset value before any write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= MODE_RST;
        else if (hw_fwd)
            mode_q <= MODE_RST;
        else if (mode_wr)
            mode_q <= mode_wdata;
    end

    assign mode_sel = mode_q;
endmodule

// File: rtl/rstsel_pulse.sv
module rstsel_pulse
    import rstsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic tick,
    output logic rst_o_n
);
    pulse_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE:  if (trig) state_nx = PS_ARMED;
            PS_ARMED: if (tick) state_nx = PS_HOLD;
            PS_HOLD:  if (tick) state_nx = PS_IDLE;
            default:  state_nx = PS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            PS_IDLE:  rst_o_n = 1'b1;
            PS_ARMED: rst_o_n = 1'b0;
            PS_HOLD:  rst_o_n = 1'b0;
            default:  rst_o_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/rstsel_swreg.sv
module rstsel_swreg
    import rstsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr,
    input  logic [SWW-1:0]  sw_wdata,
    input  logic [AW-1:0]   reg_addr,
    output logic [NBLK-1:0] blk_rst,
    output logic            pin_req,
    output logic            reg_clr
);
    logic [SWW-1:0]  sw_q;
    logic [NBLK-1:0] in_rng;

    // self-clearing: bits live for one cycle after a write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sw_q <= '0;
        else if (sw_wr) sw_q <= sw_wdata;
        else            sw_q <= '0;
    end

    for (genvar i = 0; i < NBLK; i++) begin : g_rng
        localparam addr_t LO = (i == 0) ? addr_t'(0) : addr_t'(BLK_HI[(i == 0) ? 0 : i-1] + 7'd1);
        assign in_rng[i] = (reg_addr >= LO) && (reg_addr <= BLK_HI[i]);
    end

    assign blk_rst = sw_q[NBLK-1:0];
    assign pin_req = sw_q[PIN_BIT];
    assign reg_clr = |(in_rng & blk_rst);
endmodule

// File: rtl/rstsel_top.sv
module rstsel_top
    import rstsel_pkg::*;
#(
    parameter int TICK_CYCLES = 15625
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cic_evt,
    input  logic            saw_evt,
    input  logic            wdog_evt,
    input  logic            mode_wr,
    input  logic [1:0]      mode_wdata,
    input  logic            sw_wr,
    input  logic [SWW-1:0]  sw_wdata,
    input  logic [AW-1:0]   reg_addr,
    output logic            rst_o_n,
    output logic [1:0]      mode_sel,
    output logic [NBLK-1:0] blk_rst,
    output logic            reg_clr
);
    logic tick;
    logic hw_fwd;
    logic pin_req;
    logic trig;

    rstsel_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rstsel_src_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .cic_evt(cic_evt), .saw_evt(saw_evt), .wdog_evt(wdog_evt),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_sel(mode_sel), .hw_fwd(hw_fwd)
    );

    rstsel_swreg u_sw (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .reg_addr(reg_addr),
        .blk_rst(blk_rst), .pin_req(pin_req), .reg_clr(reg_clr)
    );

    assign trig = hw_fwd || pin_req;

    rstsel_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(trig), .tick(tick), .rst_o_n(rst_o_n)
    );
endmodule

// File: rtl/rstsel_chk.sv
module rstsel_chk #(
    parameter int TICK_CYCLES = 15625
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cic_evt,
    input logic       saw_evt,
    input logic       wdog_evt,
    input logic       sw_wr,
    input logic       pin_req,
    input logic [1:0] mode_sel,
    input logic       rst_o_n,
    input logic [5:0] blk_rst,
    input logic       reg_clr
);
    localparam int LW = $clog2(2 * TICK_CYCLES + 2) + 1;
    localparam logic [LW-1:0] LMAX = LW'(2 * TICK_CYCLES);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt <= '0;
        else if (!rst_o_n) low_cnt <= low_cnt + 1'b1;
        else               low_cnt <= '0;
    end

    // R2
    wake_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_o_n && mode_sel == 2'b00 && (cic_evt || saw_evt)) |=> !rst_o_n);

    // R4
    rsvd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_o_n && mode_sel == 2'b01 && !pin_req) |=> rst_o_n);

    // R5
    width_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_o_n |-> (low_cnt < LMAX));

    // R7
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] && wdog_evt) |=> (mode_sel == 2'b00));

    // R8
    strobe_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> (blk_rst == 6'd0));

    // R10
    regclr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr |-> (blk_rst != 6'd0));
endmodule

bind rstsel_top rstsel_chk #(.TICK_CYCLES(TICK_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cic_evt(cic_evt), .saw_evt(saw_evt),
    .wdog_evt(wdog_evt), .sw_wr(sw_wr), .pin_req(pin_req),
    .mode_sel(mode_sel), .rst_o_n(rst_o_n), .blk_rst(blk_rst), .reg_clr(reg_clr)
);

// File: tb/sim_rstsel_top.sv
`timescale 1ns/1ps
module sim_rstsel_top;
    localparam int TK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cic_evt = 1'b0, saw_evt = 1'b0, wdog_evt = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       sw_wr = 1'b0;
    logic [6:0] sw_wdata = 7'd0;
    logic [6:0] reg_addr = 7'd0;
    logic       rst_o_n;
    logic [1:0] mode_sel;
    logic [5:0] blk_rst;
    logic       reg_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int hi_tab [6] = '{'h2F, 'h3F, 'h5B, 'h5F, 'h6F, 'h7F};

    always #4 clk = ~clk;

    rstsel_top #(.TICK_CYCLES(TK)) u0 (
        .clk(clk), .rst_n(rst_n), .cic_evt(cic_evt), .saw_evt(saw_evt),
        .wdog_evt(wdog_evt), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .reg_addr(reg_addr),
        .rst_o_n(rst_o_n), .mode_sel(mode_sel), .blk_rst(blk_rst), .reg_clr(reg_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic fire(input int which);
        case (which)
            0: cic_evt = 1'b1;
            1: saw_evt = 1'b1;
            default: wdog_evt = 1'b1;
        endcase
        step();
        cic_evt = 1'b0; saw_evt = 1'b0; wdog_evt = 1'b0;
    endtask

    task automatic measure(output int w);
        w = 0;
        while (!rst_o_n && w < 100) begin
            w++;
            step();
        end
    endtask

    task automatic expect_pulse(input string req);
        int w;
        chk(rst_o_n == 1'b0, req, rst_o_n, 0);
        measure(w);
        // R5
        chk(w >= TK + 1 && w <= 2 * TK, "R5", w, 2 * TK);
        step();
    endtask

    task automatic expect_quiet(input string req, input logic [1:0] m);
        for (int i = 0; i < 4; i++) begin
            chk(rst_o_n == 1'b1, req, rst_o_n, 1);
            step();
        end
        chk(mode_sel == m, "R7", mode_sel, m);
    endtask

    task automatic t_reset();
        chk(rst_o_n == 1'b1, "R1", rst_o_n, 1);
        chk(mode_sel == 2'b00, "R1", mode_sel, 0);
        chk(blk_rst == 6'd0, "R1", blk_rst, 0);
    endtask

    task automatic t_mode_write();
        set_mode(2'b11);
        chk(mode_sel == 2'b11, "R11", mode_sel, 3);
        set_mode(2'b01);
        chk(mode_sel == 2'b01, "R11", mode_sel, 1);
    endtask

    task automatic t_sel00();
        set_mode(2'b00);
        fire(0);
        chk(mode_sel == 2'b00, "R7", mode_sel, 0);
        expect_pulse("R2");
        fire(1);
        expect_pulse("R2");
        fire(2);
        expect_quiet("R2", 2'b00);
    endtask

    task automatic t_sel1x();
        set_mode(2'b10);
        fire(2);
        chk(mode_sel == 2'b00, "R7", mode_sel, 0);
        expect_pulse("R3");
        set_mode(2'b11);
        fire(0);
        expect_quiet("R3", 2'b11);
        fire(1);
        expect_quiet("R3", 2'b11);
        fire(2);
        chk(mode_sel == 2'b00, "R7", mode_sel, 0);
        expect_pulse("R3");
    endtask

    task automatic t_sel01();
        set_mode(2'b01);
        fire(0);
        expect_quiet("R4", 2'b01);
        fire(1);
        expect_quiet("R4", 2'b01);
        fire(2);
        expect_quiet("R4", 2'b01);
        sw_wr = 1'b1; sw_wdata = 7'h40;
        step();
        sw_wr = 1'b0; sw_wdata = 7'd0;
        step();
        chk(mode_sel == 2'b01, "R9", mode_sel, 1);
        expect_pulse("R4");
        chk(mode_sel == 2'b01, "R9", mode_sel, 1);
    endtask

    task automatic t_sw_pin_all();
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            sw_wr = 1'b1; sw_wdata = 7'h40;
            step();
            sw_wr = 1'b0; sw_wdata = 7'd0;
            step();
            chk(rst_o_n == 1'b0, "R9", rst_o_n, 0);
            chk(mode_sel == 2'(m), "R9", mode_sel, m);
            expect_pulse("R9");
        end
    endtask

    task automatic t_no_extend();
        int w;
        set_mode(2'b00);
        cic_evt = 1'b1;
        step();
        w = 0;
        while (!rst_o_n && w < 100) begin
            w++;
            step();
        end
        cic_evt = 1'b0;
        // R6: constant requests during the pulse must not stretch it
        chk(w >= TK + 1 && w <= 2 * TK, "R6", w, 2 * TK);
        step();
        chk(rst_o_n == 1'b1, "R6", rst_o_n, 1);
        step();
    endtask

    task automatic t_clear_priority();
        set_mode(2'b10);
        wdog_evt = 1'b1; mode_wr = 1'b1; mode_wdata = 2'b11;
        step();
        wdog_evt = 1'b0; mode_wr = 1'b0;
        chk(mode_sel == 2'b00, "R7", mode_sel, 0);
        expect_pulse("R3");
    endtask

    task automatic probe(input int k, input int addr, input bit exp);
        reg_addr = 7'(addr);
        sw_wr = 1'b1; sw_wdata = 7'(1 << k);
        step();
        sw_wr = 1'b0; sw_wdata = 7'd0;
        chk(blk_rst == 6'(1 << k), "R8", blk_rst, 1 << k);
        chk(reg_clr == exp, "R10", reg_clr, exp);
        step();
        chk(blk_rst == 6'd0, "R8", blk_rst, 0);
        chk(reg_clr == 1'b0, "R10", reg_clr, 0);
        chk(rst_o_n == 1'b1, "R8", rst_o_n, 1);
    endtask

    task automatic t_ranges();
        for (int k = 0; k < 6; k++) begin
            int lo = (k == 0) ? 0 : hi_tab[k-1] + 1;
            probe(k, lo, 1'b1);
            probe(k, hi_tab[k], 1'b1);
            if (k > 0) probe(k, lo - 1, 1'b0);
            if (k < 5) probe(k, hi_tab[k] + 1, 1'b0);
        end
        reg_addr = 7'h5D;
        sw_wr = 1'b1; sw_wdata = 7'h3F;
        step();
        sw_wr = 1'b0; sw_wdata = 7'd0;
        chk(blk_rst == 6'h3F, "R8", blk_rst, 'h3F);
        chk(reg_clr == 1'b1, "R10", reg_clr, 1);
        step();
        chk(blk_rst == 6'd0, "R8", blk_rst, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_mode_write();
        t_sel00();
        t_sel1x();
        t_sel01();
        t_sw_pin_all();
        t_no_extend();
        t_clear_priority();
        t_ranges();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule